// File: doc/BRIEF.md
# Token-Passing Sparsified Pixel Readout

This block collects hits from a small matrix of pixel cells and later sends them out one bit at a time. The matrix is 8x8 by default, and its size is set by parameters. Operation has two phases, chosen by an input. In the detection phase a 5-bit time counter advances once per clock. Each cell that is strobed stores the counter value in the next free slot of its two time-stamp slots.

In the readout phase, a rising edge on the token input starts a scan of the cells in row-major order. The token passes over empty cells. Each occupied cell hands one word to the serializer and is cleared. The serializer sends that word MSB-first, one bit per clock. Words from successive cells follow each other with no idle clocks between them. When no occupied cell is left, the token output rises.

A per-pixel kill mask blocks recording for selected cells. A master clear input empties every cell.

Top module: `pixel_token_readout`

## Requirements
- R1: After reset, `ser_valid` and `token_out` are 0 and the time counter is 0. A hit on the first detection clock after reset therefore stores time stamp 0.
- R2: The time counter advances by one, modulo 32, on every clock edge that sees `readout_phase`=0. It holds its value on every clock edge that sees `readout_phase`=1. A hit stores the counter value from before that edge's increment.
- R3: A cell keeps at most two hits. The first hit fills slot A and sets slot B to 0. The second hit fills slot B. Any further hit is dropped until the cell is cleared.
- R4: A strobe on a pixel whose `kill_mask` bit is 1 is not recorded.
- R5: When `master_clr` is 1 at a clock edge, every cell is emptied at that edge. Hits strobed at that same edge are lost.
- R6: Readout starts only on a 0-to-1 change of `token_in` while `readout_phase`=1. The first serial bit appears one clock after the edge on which that change is seen.
- R7: Each word is 24 bits, sent MSB-first. From MSB to LSB it holds: row (3 bits), column (3 bits), slot A (5 bits), slot B (5 bits), hit count (2 bits, value 1 or 2), and 6 zero bits. The pixel index equals row*8+column, and it is the index of the bit in `hit_strobe` and `kill_mask`.
- R8: Occupied cells are sent in increasing index order, with empty cells skipped. Words follow one another with no gap between them.
- R9: `ser_valid` is 1 only during the serial bits. `token_out` rises one clock after the last bit, or one clock after the start edge when no cell is occupied. It then stays at 1 until `token_in` returns to 0 or the phase ends, and it is never 1 together with `ser_valid`.
- R10: A cell is emptied once its word is taken, so a second token pass without new hits returns no words.
- R11: Strobes seen while `readout_phase`=1 are not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for cells and serializer |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_clr | input | 1 | Synchronous clear of all stored hits |
| readout_phase | input | 1 | 0 selects detection, 1 selects readout |
| hit_strobe | input | ROWS*COLS | One hit strobe per pixel, index row*COLS+col |
| kill_mask | input | ROWS*COLS | 1 disables recording for that pixel |
| token_in | input | 1 | Readout starts on its rising edge |
| ser_data | output | 1 | Serial word bit, MSB first |
| ser_valid | output | 1 | High while `ser_data` carries a word bit |
| token_out | output | 1 | High once every occupied cell has been read |

## Verification
A strobe or a master clear presented before a clock edge takes effect at that edge. For strobes, the effect only shows up in the next readout. With `token_in` raised after edge E0-1, the start is seen at E0, and bit n of the stream is due just after edge E0+n. `token_out` is due just after edge E0+24K, where K is the number of occupied cells (just after E0 when K=0). The bench raises inputs 1 ns after an edge and samples 1 ns after the following edge. It assembles each 24-bit word from exactly those sampling points and compares it with a word built from its own record of strobes and time values.

// File: rtl/pixel_token_readout.sv
`timescale 1ns/1ps
module pixel_token_readout #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int TSW  = 5,
  parameter int PAD  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 master_clr,
  input  logic                 readout_phase,
  input  logic [ROWS*COLS-1:0] hit_strobe,
  input  logic [ROWS*COLS-1:0] kill_mask,
  input  logic                 token_in,
  output logic                 ser_data,
  output logic                 ser_valid,
  output logic                 token_out
);
  localparam int NPIX   = ROWS * COLS;
  localparam int RW     = $clog2(ROWS);
  localparam int CW     = $clog2(COLS);
  localparam int IW     = RW + CW;
  localparam int PW     = IW + 1;
  localparam int WORD_W = IW + 2 * TSW + 2 + PAD;
  localparam int BW     = $clog2(WORD_W);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} st_t;

  logic [1:0]       hcnt [NPIX];
  logic [TSW-1:0]   ts_a [NPIX];
  logic [TSW-1:0]   ts_b [NPIX];
  logic [TSW-1:0]   ts_cnt;
  logic [2*NPIX-1:0] cnt_flat;
  st_t              state;
  logic             tok_q;
  logic [PW-1:0]    ptr;
  logic [BW-1:0]    bitc;
  logic [WORD_W-1:0] sreg;

  logic [PW-1:0]    start;
  logic             nxt_found;
  logic [IW-1:0]    nxt_idx;
  logic             tok_rise;
  logic             last_bit;
  logic             load;
  logic [WORD_W-1:0] word;

  assign tok_rise = token_in && !tok_q;
  assign last_bit = (state == ST_SHIFT) && (bitc == BW'(WORD_W - 1));
  assign start    = (state == ST_IDLE) ? '0 : ptr;
  assign load     = readout_phase && nxt_found &&
                    (((state == ST_IDLE) && tok_rise) || last_bit);
  assign word     = {nxt_idx[IW-1:CW], nxt_idx[CW-1:0], ts_a[nxt_idx],
                     ts_b[nxt_idx], hcnt[nxt_idx], {PAD{1'b0}}};

  always_comb begin
    nxt_found = 1'b0;
    nxt_idx   = '0;
    for (int i = NPIX - 1; i >= 0; i--) begin
      if (hcnt[i] != 2'd0 && PW'(i) >= start) begin
        nxt_found = 1'b1;
        nxt_idx   = IW'(i);
      end
    end
  end

  generate
    for (genvar g = 0; g < NPIX; g++) begin : g_flat
      assign cnt_flat[2*g +: 2] = hcnt[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPIX; p++) begin
        hcnt[p] <= 2'd0;
        ts_a[p] <= '0;
        ts_b[p] <= '0;
      end
    end else begin
      for (int p = 0; p < NPIX; p++) begin
        if (master_clr || (load && nxt_idx == IW'(p))) begin
          hcnt[p] <= 2'd0;
        end else if (!readout_phase && hit_strobe[p] && !kill_mask[p]) begin
          if (hcnt[p] == 2'd0) begin
            ts_a[p] <= ts_cnt;
            ts_b[p] <= '0;
            hcnt[p] <= 2'd1;
          end else if (hcnt[p] == 2'd1) begin
            ts_b[p] <= ts_cnt;
            hcnt[p] <= 2'd2;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_cnt <= '0;
      tok_q  <= 1'b0;
      state  <= ST_IDLE;
      ptr    <= '0;
      bitc   <= '0;
      sreg   <= '0;
    end else begin
      tok_q <= token_in;
      if (!readout_phase) ts_cnt <= ts_cnt + 1'b1;
      if (!readout_phase) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: if (tok_rise) begin
            if (nxt_found) begin
              sreg  <= word;
              bitc  <= '0;
              ptr   <= {1'b0, nxt_idx} + PW'(1);
              state <= ST_SHIFT;
            end else begin
              state <= ST_DONE;
            end
          end
          ST_SHIFT: if (last_bit) begin
            if (nxt_found) begin
              sreg <= word;
              bitc <= '0;
              ptr  <= {1'b0, nxt_idx} + PW'(1);
            end else begin
              state <= ST_DONE;
            end
          end else begin
            sreg <= {sreg[WORD_W-2:0], 1'b0};
            bitc <= bitc + 1'b1;
          end
          ST_DONE: if (!token_in) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign ser_valid = (state == ST_SHIFT);
  assign ser_data  = ser_valid && sreg[WORD_W-1];
  assign token_out = (state == ST_DONE);
endmodule

// File: rtl/pixel_token_readout_chk.sv
`timescale 1ns/1ps
module pixel_token_readout_chk #(
  parameter int NPIX = 64,
  parameter int TSW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_clr,
  input logic              readout_phase,
  input logic              token_in,
  input logic              ser_valid,
  input logic              token_out,
  input logic [TSW-1:0]    ts_now,
  input logic [2*NPIX-1:0] cnt_flat
);
  // R9
  valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> !token_out);
  // R9
  tok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    token_out && token_in && readout_phase |=> token_out);
  // R9
  valid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_valid) && $past(readout_phase) |-> token_out);
  // R2
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    readout_phase |=> $stable(ts_now));
  // R2
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !readout_phase |=> (ts_now - $past(ts_now)) == TSW'(1));
  // R6
  tok_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !readout_phase |=> !ser_valid && !token_out);
  // R5
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_clr |=> cnt_flat == '0);
  generate
    for (genvar g = 0; g < NPIX; g++) begin : g_cap
      // R3
      cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_flat[2*g +: 2] != 2'd3);
    end
  endgenerate
endmodule

bind pixel_token_readout pixel_token_readout_chk #(.NPIX(ROWS*COLS), .TSW(TSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_clr(master_clr), .readout_phase(readout_phase),
  .token_in(token_in), .ser_valid(ser_valid), .token_out(token_out),
  .ts_now(ts_cnt), .cnt_flat(cnt_flat));

// File: tb/pixel_token_readout_test.sv
`timescale 1ns/1ps
module pixel_token_readout_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclr = 1'b0, phase = 1'b0, tok = 1'b0;
  logic [63:0] hit = '0, kill = '0;
  logic sdata, svalid, tout;
  int checks = 0, failures = 0;
  int mcnt [64];
  logic [4:0] ma [64], mb [64];
  logic [4:0] mts = '0;

  always #2 clk = ~clk;

  pixel_token_readout uut (
    .clk(clk), .rst_n(rst_n), .master_clr(mclr), .readout_phase(phase),
    .hit_strobe(hit), .kill_mask(kill), .token_in(tok),
    .ser_data(sdata), .ser_valid(svalid), .token_out(tout));

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) begin
      if (mclr) begin
        for (int p = 0; p < 64; p++) mcnt[p] = 0;
      end else if (!phase) begin
        for (int p = 0; p < 64; p++) begin
          if (hit[p] && !kill[p]) begin
            if (mcnt[p] == 0) begin ma[p] = mts; mb[p] = '0; mcnt[p] = 1; end
            else if (mcnt[p] == 1) begin mb[p] = mts; mcnt[p] = 2; end
          end
        end
      end
      if (!phase) mts = mts + 5'd1;
    end
    #1;
  endtask

  function automatic logic [23:0] eword(int p);
    return {6'(p), ma[p], mb[p], 2'(mcnt[p]), 6'b0};
  endfunction

  task automatic readout(string tag, bit second);
    int q[$];
    logic [23:0] got;
    bit bad;
    for (int p = 0; p < 64; p++) if (mcnt[p] > 0) q.push_back(p);
    phase = 1'b1;
    step();
    tok = 1'b1;
    foreach (q[w]) begin
      got = '0;
      bad = 1'b0;
      for (int b = 0; b < 24; b++) begin
        hit = {$urandom(), $urandom()};
        step();
        if (!svalid || tout) bad = 1'b1;
        got = {got[22:0], sdata};
      end
      chk(!bad && got == eword(q[w]), {tag, " R7 R8 word"}, 32'(got), 32'(eword(q[w])));
    end
    step();
    chk(tout && !svalid, {tag, " R9 token_out after last bit"}, {svalid, tout}, 2'b01);
    for (int p = 0; p < 64; p++) mcnt[p] = 0;
    step();
    chk(tout, {tag, " R9 token_out held"}, tout, 1);
    if (second) begin
      tok = 1'b0;
      step();
      chk(!tout && !svalid, "R9 idle after token drop", {svalid, tout}, 0);
      tok = 1'b1;
      step();
      chk(tout && !svalid, "R10 second pass empty", {svalid, tout}, 2'b01);
    end
    tok = 1'b0;
    hit = '0;
    step();
    phase = 1'b0;
  endtask

  task automatic detect(int n, int dens, bit use_clr);
    for (int c = 0; c < n; c++) begin
      hit = '0;
      for (int p = 0; p < 64; p++) hit[p] = ($urandom_range(99) < dens);
      mclr = use_clr && ($urandom_range(29) == 0);
      step();
    end
    hit = '0;
    mclr = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < 64; p++) begin mcnt[p] = 0; ma[p] = '0; mb[p] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(!svalid && !tout, "R1 reset outputs", {svalid, tout}, 0);
    hit[5] = 1'b1; hit[63] = 1'b1;
    step();
    hit = '0; step(); step();
    hit[5] = 1'b1; step();
    hit = '0; step();
    hit[5] = 1'b1; step();
    hit = '0;
    readout("R1 R2 R3", 1'b1);
    readout("R9 empty", 1'b0);
    hit = '1;
    repeat (3) step();
    hit = '0;
    readout("R3 R8 full", 1'b1);
    kill = {$urandom(), $urandom()};
    detect(20, 30, 1'b0);
    readout("R4 kill", 1'b0);
    kill = '0;
    detect(5, 40, 1'b0);
    mclr = 1'b1; hit = '1; step();
    mclr = 1'b0; hit = '0;
    detect(4, 5, 1'b0);
    readout("R5 clear", 1'b0);
    for (int r = 0; r < 6; r++) begin
      kill = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      detect(15 + r * 7, 8, 1'b1);
      readout("R11 random", r[0]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule